// File: doc/BRIEF.md
# Read-Sequence Protection Lock Detector

This block watches read and write cycles on a byte-wide memory port and keeps a software write-protection flag. The flag comes up set after reset. A fixed password of seven read cycles is the only way to change it. The first six reads go to a common prefix of addresses. The address of the seventh read then decides the outcome: one value clears protection and another value sets it. Only the low 13 address bits take part in the comparison. The data bus is not an input. A write cycle can never move the flag.

The block has an address comparator bank, a sequence state machine and a flag stage. The comparator bank is built by generate from a table of prefix addresses. The state machine has seven states. `SEQ_IDLE` means no progress. `SEQ_GOT1` through `SEQ_GOT6` count the prefix reads matched so far. Its transitions work as follows:
- advance: a read at the next expected prefix address moves `SEQ_GOTn` to `SEQ_GOTn+1`, and `SEQ_IDLE` to `SEQ_GOT1`.
- restart: a read that misses the expected address but hits the first prefix address goes to `SEQ_GOT1`.
- abort: any other read, or any write, goes to `SEQ_IDLE`.
- hold: a cycle with no strobe keeps the state.
- finish: any read in `SEQ_GOT6` leaves the state. If the address is a valid tail, that read also fires a lock or unlock event.

The flag stage registers the event. It updates the flag and raises a pulse of one clock.

Top module: `rdseq_guard`

## Requirements
- R1: After reset `prot_o` is 1 and both `lock_pls_o` and `unlock_pls_o` are 0.
- R2: Seven read cycles at 1823h, 1820h, 1822h, 0418h, 041Bh, 0419h, 041Ah clear the flag. The read strobe is sampled at clock edge k for the seventh read. From edge k on, `prot_o` is 0 and `unlock_pls_o` is 1 for exactly that one cycle.
- R3: The same six prefix reads followed by a read at 040Ah set the flag. The timing is the same as in R2, with `lock_pls_o` as the pulse.
- R4: Address bits 18 to 13 are ignored in every comparison.
- R5: A read whose address misses the expected next entry aborts the sequence. If that read is at 1823h, it counts as step one of a new sequence.
- R6: A cycle with `wr_stb_i` high aborts any sequence in progress. When `rd_stb_i` is high in the same cycle, that read is ignored.
- R7: Write cycles never change `prot_o` and never raise a pulse. In particular, a reset-style write command does not set protection.
- R8: Cycles with neither strobe high leave the progress of a sequence unchanged.
- R9: At most one of the two pulses is high in any cycle, and each lasts one clock. Completing the lock sequence while the flag is already set still pulses `lock_pls_o` and leaves the flag set. The unlock case behaves the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rd_stb_i | input | 1 | One cycle per read transfer |
| wr_stb_i | input | 1 | One cycle per write transfer |
| addr_i | input | 19 | Address of the current transfer |
| prot_o | output | 1 | 1 = writes protected |
| lock_pls_o | output | 1 | One-clock pulse when the lock sequence completes |
| unlock_pls_o | output | 1 | One-clock pulse when the unlock sequence completes |

## Verification
The sequence state cannot be seen directly. A wrong step count or a missed restart shows up only when a sequence ends. The block then fires a pulse one read too early or too late, or fires none, and `prot_o` moves on the cycle after the read that the bench expects to be the seventh. The stimulus therefore mixes complete, broken and restarted sequences with idle gaps and writes. A state error is then exposed within at most seven read cycles of where it occurs.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    localparam int ADDR_W  = 19;
    localparam int CMP_W   = 13;
    localparam int SEQ_LEN = 7;
    localparam int PRE_LEN = SEQ_LEN - 1;

    typedef logic [CMP_W-1:0] cmp_t;

    typedef enum logic [2:0] {
        SEQ_IDLE = 3'd0,
        SEQ_GOT1 = 3'd1,
        SEQ_GOT2 = 3'd2,
        SEQ_GOT3 = 3'd3,
        SEQ_GOT4 = 3'd4,
        SEQ_GOT5 = 3'd5,
        SEQ_GOT6 = 3'd6
    } seq_state_e;

    localparam cmp_t OPEN_TAIL = 13'h041A;
    localparam cmp_t SHUT_TAIL = 13'h040A;

    function automatic cmp_t prefix_addr(input int idx);
        cmp_t a;
        case (idx)
            0:       a = 13'h1823;
            1:       a = 13'h1820;
            2:       a = 13'h1822;
            3:       a = 13'h0418;
            4:       a = 13'h041B;
            5:       a = 13'h0419;
            default: a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/rdseq_match.sv
module rdseq_match
    import rdseq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CMP_W,
    parameter int PL = PRE_LEN
) (
    input  logic [AW-1:0] addr_i,
    output logic [PL-1:0] pre_hit_o,
    output logic          open_hit_o,
    output logic          shut_hit_o
);

    localparam logic [CW-1:0] OPEN_KEY = CW'(OPEN_TAIL);
    localparam logic [CW-1:0] SHUT_KEY = CW'(SHUT_TAIL);

    logic [CW-1:0] key;

    // upper bits never reach the comparators
    assign key = addr_i[CW-1:0];

    for (genvar g = 0; g < PL; g++) begin : g_pre
        localparam logic [CW-1:0] REF = CW'(prefix_addr(g));
        assign pre_hit_o[g] = (key == REF);
    end

    assign open_hit_o = (key == OPEN_KEY);
    assign shut_hit_o = (key == SHUT_KEY);

endmodule

// File: rtl/rdseq_fsm.sv
module rdseq_fsm
    import rdseq_pkg::*;
#(
    parameter int PL = PRE_LEN
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          rd_stb_i,
    input  logic          wr_stb_i,
    input  logic [PL-1:0] pre_hit_i,
    input  logic          open_hit_i,
    input  logic          shut_hit_i,
    output logic          fire_open_o,
    output logic          fire_shut_o
);

    seq_state_e state_q, state_d, restart;
    logic       rd_only;

    assign rd_only = rd_stb_i && !wr_stb_i;
    assign restart = pre_hit_i[0] ? SEQ_GOT1 : SEQ_IDLE;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= SEQ_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_stb_i) begin
            state_d = SEQ_IDLE;
        end else if (rd_stb_i) begin
            unique case (state_q)
                SEQ_IDLE: state_d = restart;
                SEQ_GOT1: state_d = pre_hit_i[1] ? SEQ_GOT2 : restart;
                SEQ_GOT2: state_d = pre_hit_i[2] ? SEQ_GOT3 : restart;
                SEQ_GOT3: state_d = pre_hit_i[3] ? SEQ_GOT4 : restart;
                SEQ_GOT4: state_d = pre_hit_i[4] ? SEQ_GOT5 : restart;
                SEQ_GOT5: state_d = pre_hit_i[5] ? SEQ_GOT6 : restart;
                SEQ_GOT6: state_d = restart;
                default:  state_d = SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        fire_open_o = 1'b0;
        fire_shut_o = 1'b0;
        if (rd_only && state_q == SEQ_GOT6) begin
            fire_open_o = open_hit_i;
            fire_shut_o = shut_hit_i;
        end
    end

    // R6
    wr_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stb_i |=> state_q == SEQ_IDLE);

    // R8
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_stb_i && !wr_stb_i) |=> $stable(state_q));

    // R5
    stray_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_only && !(|pre_hit_i)) |=> state_q == SEQ_IDLE);

endmodule

// File: rtl/rdseq_flag.sv
module rdseq_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fire_open_i,
    input  logic fire_shut_i,
    output logic prot_o,
    output logic lock_pls_o,
    output logic unlock_pls_o
);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prot_o       <= 1'b1;
            lock_pls_o   <= 1'b0;
            unlock_pls_o <= 1'b0;
        end else begin
            lock_pls_o   <= fire_shut_i;
            unlock_pls_o <= fire_open_i;
            if (fire_shut_i)      prot_o <= 1'b1;
            else if (fire_open_i) prot_o <= 1'b0;
        end
    end

    // R9
    pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({lock_pls_o, unlock_pls_o}));

    // R9
    lock_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_pls_o |=> !lock_pls_o);

    // R9
    unlock_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unlock_pls_o |=> !unlock_pls_o);

    // R2
    open_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unlock_pls_o |-> !prot_o);

    // R3
    shut_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_pls_o |-> prot_o);

    // R7
    flag_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(prot_o) |-> (lock_pls_o || unlock_pls_o));

endmodule

// File: rtl/rdseq_guard.sv
module rdseq_guard
    import rdseq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CMP_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          rd_stb_i,
    input  logic          wr_stb_i,
    input  logic [AW-1:0] addr_i,
    output logic          prot_o,
    output logic          lock_pls_o,
    output logic          unlock_pls_o
);

    logic [PRE_LEN-1:0] pre_hit;
    logic               open_hit, shut_hit;
    logic               fire_open, fire_shut;

    rdseq_match #(.AW(AW), .CW(CW), .PL(PRE_LEN)) u_match (
        .addr_i     (addr_i),
        .pre_hit_o  (pre_hit),
        .open_hit_o (open_hit),
        .shut_hit_o (shut_hit)
    );

    rdseq_fsm #(.PL(PRE_LEN)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rd_stb_i    (rd_stb_i),
        .wr_stb_i    (wr_stb_i),
        .pre_hit_i   (pre_hit),
        .open_hit_i  (open_hit),
        .shut_hit_i  (shut_hit),
        .fire_open_o (fire_open),
        .fire_shut_o (fire_shut)
    );

    rdseq_flag u_flag (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .fire_open_i  (fire_open),
        .fire_shut_i  (fire_shut),
        .prot_o       (prot_o),
        .lock_pls_o   (lock_pls_o),
        .unlock_pls_o (unlock_pls_o)
    );

    // R4
    hi_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_stb_i && !wr_stb_i && addr_i[CW-1:0] == CW'(13'h1823)) |-> pre_hit[0]);

endmodule

// File: tb/tb_rdseq_guard.sv
`timescale 1ns/1ps
module tb_rdseq_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [18:0] addr = '0;
    logic        prot, lk, ul;

    int vectors = 0;
    int fails   = 0;

    int m_step = 0;
    bit e_prot = 1'b1;
    bit e_lk   = 1'b0;
    bit e_ul   = 1'b0;

    always #4 clk = ~clk;

    rdseq_guard dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .rd_stb_i     (rd),
        .wr_stb_i     (wr),
        .addr_i       (addr),
        .prot_o       (prot),
        .lock_pls_o   (lk),
        .unlock_pls_o (ul)
    );

    function automatic logic [12:0] bseq(input int i);
        case (i)
            0: return 13'h1823;
            1: return 13'h1820;
            2: return 13'h1822;
            3: return 13'h0418;
            4: return 13'h041B;
            5: return 13'h0419;
            default: return 13'h0000;
        endcase
    endfunction

    task automatic compare(input string tag);
        vectors++;
        if (prot !== e_prot || lk !== e_lk || ul !== e_ul) begin
            fails++;
            $display("FAIL %s: prot/lock/unlock got %b%b%b expected %b%b%b",
                     tag, prot, lk, ul, e_prot, e_lk, e_ul);
        end
    endtask

    // called at a falling edge: drive, predict, wait for the next falling edge, check
    task automatic cyc(input bit r, input bit w, input logic [18:0] a, input string tag);
        logic [12:0] k;
        rd = r; wr = w; addr = a;
        k = a[12:0];
        e_lk = 1'b0; e_ul = 1'b0;
        if (w) begin
            m_step = 0;
        end else if (r) begin
            if (m_step == 6) begin
                if (k == 13'h041A) begin e_ul = 1'b1; e_prot = 1'b0; end
                else if (k == 13'h040A) begin e_lk = 1'b1; e_prot = 1'b1; end
                m_step = (k == 13'h1823) ? 1 : 0;
            end else if (k == bseq(m_step)) begin
                m_step++;
            end else begin
                m_step = (k == 13'h1823) ? 1 : 0;
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic full_seq(input bit shut, input logic [5:0] hi, input string tag);
        for (int i = 0; i < 6; i++) cyc(1, 0, {hi, bseq(i)}, tag);
        cyc(1, 0, {hi, shut ? 13'h040A : 13'h041A}, tag);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");
        cyc(0, 0, 19'h0, "R1 idle");

        full_seq(1'b0, 6'h00, "R2 unlock");
        full_seq(1'b1, 6'h00, "R3 lock");
        full_seq(1'b0, 6'h3F, "R4 high bits set");
        full_seq(1'b1, 6'h15, "R4 high bits mixed");

        // R5: broken after three steps, then finished: must not unlock
        for (int i = 0; i < 3; i++) cyc(1, 0, {6'h0, bseq(i)}, "R5 prefix");
        cyc(1, 0, 19'h01821, "R5 miss");
        for (int i = 3; i < 6; i++) cyc(1, 0, {6'h0, bseq(i)}, "R5 tail");
        cyc(1, 0, 19'h0041A, "R5 no unlock");

        // R5: restart on first entry mid-sequence
        for (int i = 0; i < 4; i++) cyc(1, 0, {6'h0, bseq(i)}, "R5 part");
        full_seq(1'b0, 6'h00, "R5 restart unlock");

        // R6: write in the middle
        for (int i = 0; i < 3; i++) cyc(1, 0, {6'h0, bseq(i)}, "R6 pre");
        cyc(0, 1, {6'h0, bseq(3)}, "R6 write");
        for (int i = 3; i < 6; i++) cyc(1, 0, {6'h0, bseq(i)}, "R6 rest");
        cyc(1, 0, 19'h0040A, "R6 no lock");
        // R6: read and write together at step six
        for (int i = 0; i < 6; i++) cyc(1, 0, {6'h0, bseq(i)}, "R6 pre2");
        cyc(1, 1, 19'h0040A, "R6 rd+wr ignored");

        // R7: write cycles including a reset-style command
        for (int i = 0; i < 5; i++) cyc(0, 1, 19'h000FF + 19'(i), "R7 writes");
        cyc(0, 1, 19'h0040A, "R7 write tail");

        // R8: gaps between reads
        for (int i = 0; i < 6; i++) begin
            cyc(1, 0, {6'h0, bseq(i)}, "R8 read");
            cyc(0, 0, 19'h1234, "R8 gap");
            cyc(0, 0, 19'h0040A, "R8 gap");
        end
        cyc(1, 0, 19'h0040A, "R8 lock after gaps");

        // R9: lock again while locked
        full_seq(1'b1, 6'h01, "R9 relock");
        cyc(0, 0, 19'h0, "R9 pulse gone");

        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [5:0] hi;
            r  = int'($urandom % 16);
            hi = 6'($urandom);
            if (r < 9) begin
                if (m_step < 6) cyc(1, 0, {hi, bseq(m_step)}, "R9 random");
                else cyc(1, 0, {hi, ($urandom % 2) ? 13'h040A : 13'h041A}, "R9 random");
            end else if (r < 12) cyc(0, 0, 19'($urandom), "R8 random");
            else if (r == 12) cyc(1, 0, 19'($urandom), "R5 random");
            else if (r == 13) cyc(0, 1, 19'($urandom), "R7 random");
            else if (r == 14) cyc(1, 0, {hi, 13'h1823}, "R5 random");
            else cyc(1, 1, {hi, bseq(m_step % 6)}, "R6 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule